// File: doc/BRIEF.md
# Per-Pin Edge Wakeup Latch

This block watches an 8-bit input port and latches a chosen edge on each pin into a pending register. Software picks the edge for each pin: rising or falling. Software also clears pending bits one at a time by writing a mask. A third register selects which pending bits may wake the core. Every pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with the level one cycle earlier. Edge detection stays off for the first few cycles after reset, while the synchronizer fills, so a pin that starts high does not look like a rising edge.

The block computes one term: at least one bit is both enabled and pending. Two outputs come from that term. The HALT-inhibit output is combinational, so power control sees it at once. The wakeup request is the same term delayed by one register. A pending bit latches its edge even when its enable bit is 0. A clean reconfiguration therefore works as follows: disable the pin, change its edge, clear its pending bit, then enable it again. No wakeup leaks out during that sequence.

The register port is a plain single-cycle bus. A write happens on the rising clock edge when both select and write-enable are high. Read data is combinational from the address. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `pinwake_top`

## Requirements
- R1: While reset is asserted and right after it, the enable register (address 0) and the edge-select register (address 1) read 0. Reset does not initialize the pending register (address 2), so after reset it keeps the value it held before.
- R2: Addresses 0 and 1 read back the last value written to them. Address 3 always reads 0, and writes to address 3 change no register.
- R3: With edge-select bit 0, a low-to-high change on that pin sets its pending bit. If the pin changes just before rising edge k, the bit reads 1 after edge k+2 and not before.
- R4: With edge-select bit 1, a high-to-low change sets the pending bit. A change of the opposite polarity never sets the pending bit.
- R5: A write to address 2 clears each pending bit whose data bit is 0. It leaves each pending bit whose data bit is 1 unchanged. A write cannot set a pending bit.
- R6: If a selected edge sets a pending bit in the same cycle that a write clears it, the bit ends up set.
- R7: A pending bit latches its selected edge whether or not its enable bit is set. wake_req stays 0 while no pending bit is enabled.
- R8: halt_block is 1 in exactly those cycles in which some bit is both enabled and pending. wake_req equals halt_block delayed by one clock.
- R9: The sequence "clear enable bit, change edge-select bit, clear pending bit, set enable bit" raises no wakeup, even if that pin toggles while its enable bit is clear.
- R10: No edge is detected in the first three cycles after reset is released, whatever levels the pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 8 | Asynchronous port pins |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 enable, 1 edge select, 2 pending, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| halt_block | output | 1 | At least one bit is enabled and pending |
| wake_req | output | 1 | Registered wakeup request |

## Verification
On every cycle, the assertions check the following: no pending bit rises without a detected edge, an edge beats a clearing write, each detected edge matches its pin's selected polarity, wake_req follows halt_block by one clock, and both configuration registers clear on reset. Only the bench's scenarios can show the rest. These are the full polarity sweep across all pins, the exact settle latency, the mask-clear semantics, that the pending register survives reset, that the post-reset priming window hides edges, and that the safe reconfiguration sequence never produces a wakeup.

// File: rtl/pinwake_pkg.sv
package pinwake_pkg;
  localparam int REG_AW = 2;
  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE  = 2'd0,
    RA_EDGESEL = 2'd1,
    RA_PENDING = 2'd2,
    RA_UNUSED  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pinwake_sync.sv
module pinwake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinwake_edge.sv
module pinwake_edge #(
  parameter int WIDTH      = 8,
  parameter int PRIME_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  output logic [WIDTH-1:0] edge_o
);
  localparam int CW = $clog2(PRIME_CYC + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CW-1:0]    prime_cnt_q;
  logic             primed;

  assign primed = (prime_cnt_q == CW'(PRIME_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      prime_cnt_q <= '0;
    end else begin
      prev_q <= level_i;
      if (!primed) prime_cnt_q <= prime_cnt_q + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall;
      assign rise = level_i[i] & ~prev_q[i];
      assign fall = ~level_i[i] & prev_q[i];
      assign edge_o[i] = primed & (fall_sel_i[i] ? fall : rise);
    end
  endgenerate
endmodule

// File: rtl/pinwake_regs.sv
module pinwake_regs
  import pinwake_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  edge_i,
  output logic [WIDTH-1:0]  enable_o,
  output logic [WIDTH-1:0]  fall_sel_o,
  output logic [WIDTH-1:0]  pending_o
);
  logic [WIDTH-1:0] en_q, sel_q, pend_q;
  logic             wr;
  logic [WIDTH-1:0] clr_mask;

  assign wr       = bus_sel & bus_we;
  assign clr_mask = (wr && reg_addr_e'(bus_addr) == RA_PENDING) ? ~bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (wr) begin
      if (reg_addr_e'(bus_addr) == RA_ENABLE)  en_q  <= bus_wdata;
      if (reg_addr_e'(bus_addr) == RA_EDGESEL) sel_q <= bus_wdata;
    end
  end

  // pending has no reset: it holds across reset
  always_ff @(posedge clk) begin
    pend_q <= (pend_q & ~clr_mask) | edge_i;
  end

  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      RA_ENABLE:  bus_rdata = en_q;
      RA_EDGESEL: bus_rdata = sel_q;
      RA_PENDING: bus_rdata = pend_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign enable_o   = en_q;
  assign fall_sel_o = sel_q;
  assign pending_o  = pend_q;

  // R3
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_i)) == '0));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i) |=> ((pend_q & $past(edge_i)) == $past(edge_i)));

  // R1
  cfg_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && sel_q == '0));
endmodule

// File: rtl/pinwake_top.sv
module pinwake_top
  import pinwake_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pins_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              halt_block,
  output logic              wake_req
);
  localparam int PRIME_CYC = SYNC_STAGES + 1;

  logic [WIDTH-1:0] sync_v, edge_v, en_v, sel_v, pend_v;
  logic             wake_q;

  pinwake_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(sync_v)
  );

  pinwake_edge #(.WIDTH(WIDTH), .PRIME_CYC(PRIME_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(sync_v), .fall_sel_i(sel_v),
    .edge_o(edge_v)
  );

  pinwake_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .edge_i(edge_v), .enable_o(en_v), .fall_sel_o(sel_v), .pending_o(pend_v)
  );

  assign halt_block = |(en_v & pend_v);

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= halt_block;
  end
  assign wake_req = wake_q;

  // R4
  edge_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v & ~(sync_v ^ sel_v)) == '0);

  // R8
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_block |=> wake_req);

  // R8
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(halt_block));
endmodule

// File: tb/pinwake_top_bench.sv
module pinwake_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       halt_block, wake_req;

  int checks = 0, fails = 0;
  bit mon_on = 0, mon_hit = 0;

  always #5 clk = ~clk;

  pinwake_top u_pinwake_top (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .halt_block(halt_block), .wake_req(wake_req)
  );

  always @(negedge clk) if (mon_on && wake_req) mon_hit = 1;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic setpins(logic [7:0] v);
    @(negedge clk); pins = v; settle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(0, r); chk("R1 enable in reset", r, 8'h00);
    rd(1, r); chk("R1 edgesel in reset", r, 8'h00);
    chk("R1 halt_block", {7'd0, halt_block}, 8'h00);
    chk("R1 wake_req", {7'd0, wake_req}, 8'h00);
    @(negedge clk); rst_n = 1;
    settle();
    wr(2, 8'h00);

    // R2
    wr(0, 8'h00); wr(1, 8'hA5);
    rd(1, r); chk("R2 edgesel readback", r, 8'hA5);
    wr(3, 8'hFF);
    rd(3, r); chk("R2 addr3 reads zero", r, 8'h00);
    rd(1, r); chk("R2 addr3 write ignored edgesel", r, 8'hA5);
    rd(0, r); chk("R2 addr3 write ignored enable", r, 8'h00);
    rd(2, r); chk("R2 addr3 write ignored pending", r, 8'h00);

    // R3/R4/R7 sweep, enable=0
    for (int s = 0; s < 2; s++) begin
      wr(1, s ? 8'hFF : 8'h00);
      for (int i = 0; i < 8; i++) begin
        for (int d = 0; d < 2; d++) begin
          logic [7:0] base, exp;
          base = d ? (pins & ~(8'd1 << i)) : (pins | (8'd1 << i));
          setpins(base);
          wr(2, 8'h00);
          setpins(base ^ (8'd1 << i));
          exp = ((d == 1 && s == 0) || (d == 0 && s == 1)) ? (8'd1 << i) : 8'h00;
          rd(2, r);
          chk(s ? "R4 falling select" : "R3 rising select", r, exp);
          chk("R7 no wake while disabled", {7'd0, wake_req}, 8'h00);
        end
      end
    end

    // R3 latency + R8 timing
    wr(1, 8'h00); setpins(8'h00); wr(2, 8'h00); wr(0, 8'h01);
    @(negedge clk); pins = 8'h01;
    @(negedge clk); @(negedge clk);
    bus_addr = 2; #1 chk("R3 not yet after edge k+1", bus_rdata, 8'h00);
    @(negedge clk); bus_addr = 2; #1 chk("R3 set after edge k+2", bus_rdata, 8'h01);
    chk("R8 halt_block immediate", {7'd0, halt_block}, 8'h01);
    chk("R8 wake one cycle later", {7'd0, wake_req}, 8'h00);
    @(negedge clk); chk("R8 wake raised", {7'd0, wake_req}, 8'h01);

    // R5 mask clear
    wr(0, 8'h00);
    setpins(8'hFF); // rising on pins 1..7
    rd(2, r); chk("R5 all pending", r, 8'hFF);
    wr(2, 8'hF0);
    rd(2, r); chk("R5 clear low nibble", r, 8'hF0);
    chk("R8 halt low when disabled", {7'd0, halt_block}, 8'h00);
    wr(2, 8'hFF);
    rd(2, r); chk("R5 ones keep", r, 8'hF0);

    // R6 edge vs clear in same cycle
    setpins(8'h00); wr(2, 8'h00);
    @(negedge clk); pins = 8'h04;
    @(negedge clk); @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 2; bus_wdata = 8'h00;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    rd(2, r); chk("R6 edge wins", r, 8'h04);

    // R1 pending survives reset; R10 priming
    wr(2, 8'h00);
    @(negedge clk); rst_n = 0; pins = 8'hFF;
    repeat (4) @(negedge clk); rst_n = 1;
    settle();
    rd(2, r); chk("R10 no edge after reset release", r, 8'h00);
    setpins(8'h00); wr(2, 8'h3C);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    settle();
    rd(2, r); chk("R1 pending kept over reset", r, 8'h00);
    setpins(8'h3C);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    rd(2, r); chk("R1 pending retained value", r, 8'h3C);
    rd(0, r); chk("R1 enable cleared", r, 8'h00);

    // R9 safe reconfiguration on pin 5
    settle(); setpins(8'h20); wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h20);
    mon_on = 1;
    wr(0, 8'h00);
    wr(1, 8'h20);
    setpins(8'h00);       // falling while disabled
    setpins(8'h20);
    setpins(8'h00);
    wr(2, 8'hDF);
    wr(0, 8'h20);
    settle();
    mon_on = 0;
    chk("R9 no wake during sequence", {7'd0, mon_hit}, 8'h00);
    setpins(8'h20);
    chk("R9 rising ignored after switch", {7'd0, wake_req}, 8'h00);
    setpins(8'h00);
    chk("R9 falling wakes after switch", {7'd0, wake_req}, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule